// File: doc/BRIEF.md
# Digital Loopback Mix Attenuator

This block feeds scaled capture samples back into the playback path. Each incoming signed 16-bit capture sample is held in a capture register. On every DAC sample strobe the held sample is multiplied by a gain factor picked by a 6-bit attenuation code, in steps of 1.5 dB. The scaled value is added to the current playback sample, and the sum is clipped to the signed 16-bit range. One mixed sample comes out one clock after each strobe. A stereo path uses one instance per channel.

A single 8-bit control byte sets up the block, written through an indexed register port. Its enable bit turns the loopback term on or off. Its upper six bits hold the attenuation code. Two fallback rules apply. A capture sample that arrives with the overrun flag is discarded, so the last good sample is used again. A missing or underrun playback sample is replaced by zero.

The capture and playback inputs are streams with valid/ready handshakes. Both ready outputs are always high, so the block never applies back-pressure. A word is accepted in any cycle where its valid is high. The mixed output is a valid-qualified sample with no ready. Whoever drives the DAC strobe must take each result in the cycle after the strobe.

Top module: `loopmix_atten`

## Requirements
- R1: After reset the control byte is 00h, `mix_valid` is 0 and `mix_data` is 0.
- R2: A write with `cfg_we`=1 and `cfg_idx`=13 loads the control byte. Bits 7:2 are the attenuation code, bit 0 is the enable bit and bit 1 is ignored. A write to any other index leaves the control byte unchanged.
- R3: `mix_valid` is 1 in exactly the cycle after `dac_strobe` is 1. Between strobes `mix_data` holds its value.
- R4: When the enable bit is 0, the capture term is zero.
- R5: When the enable bit is 1, the capture term is floor(c*G[k]/32768). Here G[k]=round(32768*10^(-1.5k/20)) for code k. Code 0 gives unity gain and code 63 gives about -94.5 dB.
- R6: The capture term is added whether or not `pb_en` is set. With `pb_en`=0 the playback term is zero.
- R7: A capture word with `cap_ovr`=1 is not stored. The last word accepted without overrun stays in use for the mix.
- R8: With `pb_en`=1, the playback term is `pb_data` only when `pb_valid`=1 and `pb_underrun`=0 at the strobe. In every other case the playback term is zero.
- R9: The sum of the two terms saturates to the range -32768..32767.
- R10: A capture word accepted in the same cycle as `dac_strobe` is the one mixed by that strobe.
- R11: `cap_ready` and `pb_ready` are always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_idx | input | 4 | Register index of the write |
| cfg_wdata | input | 8 | Control byte write data |
| cap_valid | input | 1 | Capture word valid |
| cap_ready | output | 1 | Capture ready, always 1 |
| cap_data | input | 16 | Signed capture sample |
| cap_ovr | input | 1 | Capture overrun flag for this word |
| pb_valid | input | 1 | Playback word valid |
| pb_ready | output | 1 | Playback ready, always 1 |
| pb_data | input | 16 | Signed playback sample |
| pb_underrun | input | 1 | Playback underrun flag |
| pb_en | input | 1 | Playback enable |
| dac_strobe | input | 1 | DAC sample strobe |
| mix_valid | output | 1 | Mixed sample valid, one cycle after the strobe |
| mix_data | output | 16 | Signed mixed sample |

## Verification
A capture word can arrive in the same cycle as a DAC strobe, and so can an overrun word. The bench provokes both cases. In the first, a strobe carries a fresh capture word while the register still holds an older, different value; the result must reflect the fresh word. In the second, an overrun word rides with a strobe; the result must reflect the previously stored word. A scoreboard model predicts each result, tracking its own copy of the held capture sample. The model also replaces playback with zero on underrun.

// File: rtl/loopmix_pkg.sv
package loopmix_pkg;
  localparam int SAMPLE_W = 16;
  localparam int CODE_W   = 6;
  localparam int GAIN_W   = 17;  // unsigned, 32768 == unity
  localparam int FRAC_W   = 15;

  // gain factor for code k: 1.5 dB per step, rounded to nearest
  function automatic int gain_of(int k);
    real lin;
    lin = 32768.0 * (10.0 ** (-1.5 * k / 20.0));
    return $rtoi(lin + 0.5);
  endfunction
endpackage

// File: rtl/loopmix_cfg.sv
module loopmix_cfg #(
  parameter int IDX_W   = 4,
  parameter int MIX_IDX = 13,
  parameter int CODE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CODE_W+1:0] wdata,
  output logic              en,
  output logic [CODE_W-1:0] code
);
  logic hit;
  logic unused_rsv;

  assign hit        = we && (idx == IDX_W'(MIX_IDX));
  assign unused_rsv = wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      code <= '0;
    end else if (hit) begin
      en   <= wdata[0];
      code <= wdata[CODE_W+1:2];
    end
  end
endmodule

// File: rtl/loopmix_gain_rom.sv
module loopmix_gain_rom
  import loopmix_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int GW = GAIN_W
) (
  input  logic [CW-1:0] code,
  output logic [GW-1:0] gain
);
  localparam int DEPTH = 1 << CW;

  logic [GW-1:0] lut [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_lut
    localparam int FACTOR = gain_of(k);
    assign lut[k] = GW'(FACTOR);
  end

  assign gain = lut[code];
endmodule

// File: rtl/loopmix_core.sv
module loopmix_core #(
  parameter int SW   = 16,
  parameter int GW   = 17,
  parameter int FRAC = 15
) (
  input  logic signed [SW-1:0] cap_s,
  input  logic        [GW-1:0] gain,
  input  logic                 mix_on,
  input  logic signed [SW-1:0] pb_s,
  input  logic                 pb_take,
  output logic signed [SW-1:0] sat_out
);
  localparam int PW = SW + GW + 1;
  localparam int AW = SW + 2;
  localparam logic signed [AW-1:0] MAXV = AW'((1 << (SW-1)) - 1);
  localparam logic signed [AW-1:0] MINV = -AW'(1 << (SW-1));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [AW-1:0] att;
  logic signed [AW-1:0] pbt;
  logic signed [AW-1:0] sum;

  always_comb begin
    prod   = PW'(cap_s) * $signed({1'b0, gain});
    scaled = prod >>> FRAC;
    att    = mix_on ? scaled[AW-1:0] : '0;
    pbt    = pb_take ? AW'(pb_s) : '0;
    sum    = att + pbt;
    if (sum > MAXV)      sat_out = MAXV[SW-1:0];
    else if (sum < MINV) sat_out = MINV[SW-1:0];
    else                 sat_out = sum[SW-1:0];
  end
endmodule

// File: rtl/loopmix_atten.sv
module loopmix_atten
  import loopmix_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int MIX_IDX = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [CODE_W+1:0]   cfg_wdata,
  input  logic                cap_valid,
  output logic                cap_ready,
  input  logic [SAMPLE_W-1:0] cap_data,
  input  logic                cap_ovr,
  input  logic                pb_valid,
  output logic                pb_ready,
  input  logic [SAMPLE_W-1:0] pb_data,
  input  logic                pb_underrun,
  input  logic                pb_en,
  input  logic                dac_strobe,
  output logic                mix_valid,
  output logic [SAMPLE_W-1:0] mix_data
);
  logic                       cfg_en;
  logic [CODE_W-1:0]          cfg_code;
  logic [GAIN_W-1:0]          gain;
  logic                       cap_take;
  logic signed [SAMPLE_W-1:0] cap_hold;
  logic signed [SAMPLE_W-1:0] cap_eff;
  logic                       pb_take;
  logic signed [SAMPLE_W-1:0] mixed;

  assign cap_ready = 1'b1;
  assign pb_ready  = 1'b1;

  loopmix_cfg #(.IDX_W(IDX_W), .MIX_IDX(MIX_IDX), .CODE_W(CODE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .en(cfg_en), .code(cfg_code)
  );

  loopmix_gain_rom #(.CW(CODE_W), .GW(GAIN_W)) u_rom (
    .code(cfg_code), .gain(gain)
  );

  // overrun words are dropped; a same-cycle good word bypasses the hold
  assign cap_take = cap_valid && !cap_ovr;
  assign cap_eff  = cap_take ? $signed(cap_data) : cap_hold;
  assign pb_take  = pb_en && pb_valid && !pb_underrun;

  always_ff @(posedge clk) begin
    if (!rst_n)        cap_hold <= '0;
    else if (cap_take) cap_hold <= $signed(cap_data);
  end

  loopmix_core #(.SW(SAMPLE_W), .GW(GAIN_W), .FRAC(FRAC_W)) u_core (
    .cap_s(cap_eff), .gain(gain), .mix_on(cfg_en),
    .pb_s($signed(pb_data)), .pb_take(pb_take), .sat_out(mixed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mix_valid <= 1'b0;
      mix_data  <= '0;
    end else begin
      mix_valid <= dac_strobe;
      if (dac_strobe) mix_data <= mixed;
    end
  end
endmodule

// File: rtl/loopmix_chk.sv
module loopmix_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dac_strobe,
  input logic        mix_valid,
  input logic [15:0] mix_data,
  input logic        cap_valid,
  input logic        cap_ovr,
  input logic [15:0] cap_hold,
  input logic        mix_en,
  input logic        pb_en,
  input logic        pb_valid,
  input logic        pb_underrun,
  input logic [15:0] pb_data
);
  p_strobe_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe |=> mix_valid);
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_strobe |=> !mix_valid);
  p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_strobe |=> $stable(mix_data));
  p_muted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_strobe && !mix_en && !pb_en) |=> (mix_data == 16'h0000));
  p_pb_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_strobe && !mix_en && pb_en && pb_valid && !pb_underrun)
      |=> (mix_data == $past(pb_data)));
  p_overrun_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_ovr) |=> $stable(cap_hold));
  p_underrun_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_strobe && !mix_en && pb_en && pb_underrun) |=> (mix_data == 16'h0000));
endmodule

bind loopmix_atten loopmix_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dac_strobe(dac_strobe), .mix_valid(mix_valid),
  .mix_data(mix_data), .cap_valid(cap_valid), .cap_ovr(cap_ovr),
  .cap_hold(cap_hold), .mix_en(cfg_en), .pb_en(pb_en), .pb_valid(pb_valid),
  .pb_underrun(pb_underrun), .pb_data(pb_data)
);

// File: tb/tb_loopmix_atten.sv
module tb_loopmix_atten;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cap_valid = 1'b0, cap_ovr = 1'b0;
  logic [15:0] cap_data = '0;
  logic        pb_valid = 1'b0, pb_underrun = 1'b0, pb_en = 1'b0;
  logic [15:0] pb_data = '0;
  logic        dac_strobe = 1'b0;
  logic        cap_ready, pb_ready, mix_valid;
  logic [15:0] mix_data;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  bit          m_en = 0;
  int          m_code = 0;
  int          m_hold = 0;

  always #10 clk = ~clk;

  loopmix_atten dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cap_valid(cap_valid), .cap_ready(cap_ready),
    .cap_data(cap_data), .cap_ovr(cap_ovr), .pb_valid(pb_valid),
    .pb_ready(pb_ready), .pb_data(pb_data), .pb_underrun(pb_underrun),
    .pb_en(pb_en), .dac_strobe(dac_strobe), .mix_valid(mix_valid),
    .mix_data(mix_data)
  );

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint gain_f(int k);
    return longint'($rtoi(32768.0 * (10.0 ** (-1.5 * k / 20.0)) + 0.5));
  endfunction

  task automatic cfg_write(int idx, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = 8'(val);
    if (idx == 13) begin m_en = val[0]; m_code = (val >> 2) & 63; end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cap_only(int c, bit ov);
    @(negedge clk);
    cap_valid = 1'b1; cap_data = 16'(c); cap_ovr = ov;
    if (!ov) m_hold = c;
    @(negedge clk);
    cap_valid = 1'b0; cap_ovr = 1'b0;
  endtask

  task automatic strobe(bit cv, int c, bit ov, bit pe, bit pv, bit pu, int p, string req);
    longint ce, att, pbt, sum;
    @(negedge clk);
    cap_valid = cv; cap_data = 16'(c); cap_ovr = ov;
    pb_en = pe; pb_valid = pv; pb_underrun = pu; pb_data = 16'(p);
    dac_strobe = 1'b1;
    ce  = (cv && !ov) ? longint'(c) : longint'(m_hold);
    att = m_en ? ((ce * gain_f(m_code)) >>> 15) : 0;
    pbt = (pe && pv && !pu) ? longint'(p) : 0;
    sum = att + pbt;
    if (sum > 32767) sum = 32767;
    if (sum < -32768) sum = -32768;
    exp_q.push_back(16'(sum));
    tag_q.push_back(req);
    if (cv && !ov) m_hold = c;
    @(negedge clk);
    dac_strobe = 1'b0; cap_valid = 1'b0; cap_ovr = 1'b0;
    pb_valid = 1'b0; pb_underrun = 1'b0;
  endtask

  // monitor: pops one expected item per mixed output
  always @(negedge clk) begin
    if (rst_n && mix_valid) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected mix_valid", 1, 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, longint'($signed(mix_data)), longint'($signed(e)));
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        check("watchdog", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R1 mix_valid reset", mix_valid, 0);
    check("R1 mix_data reset", mix_data, 0);
    check("R11 cap_ready", cap_ready, 1);
    check("R11 pb_ready", pb_ready, 1);
    rst_n = 1'b1;
    // R1/R4: reset control byte leaves the loopback muted
    strobe(1, 1000, 0, 0, 0, 0, 0, "R1 R4 muted after reset");
    // R2/R5/R6: unity gain, playback disabled
    cfg_write(13, 8'h01);
    strobe(1, 12000, 0, 0, 1, 0, 5000, "R5 R6 unity pb disabled");
    // R2: other index ignored
    cfg_write(5, 8'hFF);
    strobe(1, -8000, 0, 0, 0, 0, 0, "R2 other index ignored");
    // R5: 6 dB with playback
    cfg_write(13, 8'h11);
    strobe(1, 16000, 0, 1, 1, 0, 1000, "R5 code4 with playback");
    strobe(1, -16001, 0, 1, 1, 0, -200, "R5 negative floor");
    // R5: max attenuation
    cfg_write(13, 8'hFD);
    strobe(1, 32767, 0, 0, 0, 0, 0, "R5 code63");
    // R2: reserved bit ignored, code 1
    cfg_write(13, 8'h07);
    strobe(1, 20000, 0, 0, 0, 0, 0, "R2 R5 reserved bit ignored");
    // R7: overrun word dropped, even alongside the strobe
    cfg_write(13, 8'h01);
    cap_only(5000, 0);
    cap_only(-30000, 1);
    strobe(0, 0, 0, 0, 0, 0, 0, "R7 overrun reuses last");
    strobe(1, 30000, 1, 0, 0, 0, 0, "R7 overrun with strobe");
    // R10: fresh capture forwarded in the strobe cycle
    strobe(1, -1234, 0, 0, 0, 0, 0, "R10 same-cycle capture");
    // R8: underrun and missing playback replaced by zero
    strobe(1, 700, 0, 1, 1, 1, 20000, "R8 underrun zero");
    strobe(1, 700, 0, 1, 0, 0, 20000, "R8 missing playback zero");
    // R9: saturation both ways
    strobe(1, 30000, 0, 1, 1, 0, 10000, "R9 positive clip");
    strobe(1, -30000, 0, 1, 1, 0, -10000, "R9 negative clip");
    // R4/R6: disabled loopback passes playback only
    cfg_write(13, 8'h00);
    strobe(1, 9999, 0, 1, 1, 0, -4321, "R4 R6 playback only");
    // R3: output held and no valid between strobes
    @(negedge clk);
    held = mix_data;
    cap_only(111, 0);
    repeat (3) @(negedge clk);
    check("R3 hold between strobes", mix_data, held);
    check("R3 no valid without strobe", mix_valid, 0);
    repeat (3) @(negedge clk);
    check("R3 all results seen", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule